// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers up to 32 level-sensitive peripheral interrupt lines into two request lines toward a processor. Software reaches it through a small register bus with single-cycle write and read strobes and byte offsets. Per-source enable bits are set and cleared through two separate write-one registers, so no read-modify-write is needed. A per-source type register sends each source to one of the two request lines. The top bit of the enable mask is a global gate, and no request leaves the block while it is clear.

Each request line has its own status view, which holds the enabled, gated and steered sources for that line. A separate raw view shows the input levels before any masking. Sources are not latched. A request stays visible for as long as its input is high. Masking a source hides the request but does not clear anything, so unmasking a source that is still high brings the request back at once. Each request line is the OR of its status view, taken through one flop.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable mask (read at 0x34), the type register (read at 0x20) and both request outputs are zero.
- R2: A write to 0x34 sets every enable bit whose data bit is 1 and leaves the bits written 0 unchanged. A read of 0x34 returns the current enable mask.
- R3: A write to 0x38 clears every enable bit whose data bit is 1. Writing all ones clears the whole mask. A read of 0x38 returns zero.
- R4: Enable bit 31 is the global gate. While it is 0, both status views read zero and both request outputs stay low.
- R5: The type register (0x20, read/write) steers each source. A type bit of 0 sends the source to request output 0, and a 1 sends it to request output 1.
- R6: The status view at 0x00 equals raw AND enable AND NOT type. The status view at 0x04 equals raw AND enable AND type. Both views are forced to zero unless enable bit 31 is set.
- R7: The raw view at 0x30 returns the input levels whatever the enable, type and gate settings are.
- R8: Sources are level-sensitive. Masking a high source lowers its request without clearing it, unmasking it raises the request again with no new input edge, and dropping the input removes the request.
- R9: Each request output is the OR of its status view, registered, so an input change shows at the output after exactly one rising clock edge.
- R10: Writes to 0x00, 0x04 and 0x30 change no state. Reads of unmapped offsets return zero. Read data appears on the clock edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_re_i | input | 1 | Single-cycle read strobe |
| bus_addr_i | input | ADDR_W (8) | Byte offset |
| bus_wdata_i | input | SRC_W (32) | Write data |
| bus_rdata_o | output | SRC_W (32) | Read data, registered |
| irq_src_i | input | SRC_W (32) | Raw level-sensitive interrupt inputs |
| cpu_irq0_o | output | 1 | Request line 0 (type bit 0 sources) |
| cpu_irq1_o | output | 1 | Request line 1 (type bit 1 sources) |

## Verification
A corrupted enable or type bit shows up in the next read of 0x34 or 0x20, and it also shows up on a request output one edge after a matching input goes high. That makes it visible both through the bus and through the request pins. A request that was latched by mistake instead of level-tracked shows as an output that stays high for one edge after the input drops, or one that stays low after an unmask. A gate or steering error moves a request to the wrong line, or lets one out with the gate closed, within the single registered stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Byte offsets of the register window
   localparam int unsigned OFF_STAT0 = 'h00;
   localparam int unsigned OFF_STAT1 = 'h04;
   localparam int unsigned OFF_TYPE  = 'h20;
   localparam int unsigned OFF_RAW   = 'h30;
   localparam int unsigned OFF_SET   = 'h34;
   localparam int unsigned OFF_CLR   = 'h38;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_SET,
      ACC_CLR,
      ACC_TYPE
   } wr_kind_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SRC_W-1:0]  wdata_i,
   output logic [SRC_W-1:0]  en_q_o,
   output logic [SRC_W-1:0]  type_q_o
);
   wr_kind_e kind;
   logic [SRC_W-1:0] en_q, type_q;

   always_comb begin
      kind = ACC_NONE;
      if (we_i) begin
         if (addr_i == ADDR_W'(OFF_SET))       kind = ACC_SET;
         else if (addr_i == ADDR_W'(OFF_CLR))  kind = ACC_CLR;
         else if (addr_i == ADDR_W'(OFF_TYPE)) kind = ACC_TYPE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         type_q <= '0;
      end else begin
         case (kind)
            ACC_SET:  en_q   <= en_q | wdata_i;
            ACC_CLR:  en_q   <= en_q & ~wdata_i;
            ACC_TYPE: type_q <= wdata_i;
            default:  ;
         endcase
      end
   end

   assign en_q_o   = en_q;
   assign type_q_o = type_q;
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
   parameter int unsigned SRC_W = 32
) (
   input  logic [SRC_W-1:0] raw_i,
   input  logic [SRC_W-1:0] en_i,
   input  logic [SRC_W-1:0] type_i,
   output logic [SRC_W-1:0] stat0_o,
   output logic [SRC_W-1:0] stat1_o
);
   localparam int unsigned GATE_BIT = SRC_W - 1;

   logic gate;
   assign gate = en_i[GATE_BIT];

   for (genvar g = 0; g < SRC_W; g++) begin : g_src
      logic live;
      assign live       = raw_i[g] & en_i[g] & gate;
      assign stat0_o[g] = live & ~type_i[g];
      assign stat1_o[g] = live & type_i[g];
   end
endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
   parameter int unsigned SRC_W   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_W-1:0] stat0_i,
   input  logic [SRC_W-1:0] stat1_i,
   output logic             irq0_o,
   output logic             irq1_o
);
   logic any0, any1;
   assign any0 = |stat0_i;
   assign any1 = |stat1_i;

   if (OUT_REG) begin : g_reg
      logic q0, q1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
         end else begin
            q0 <= any0;
            q1 <= any1;
         end
      end
      assign irq0_o = q0;
      assign irq1_o = q1;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign irq0_o = any0;
      assign irq1_o = any1;
   end
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SRC_W-1:0]  stat0_i,
   input  logic [SRC_W-1:0]  stat1_i,
   input  logic [SRC_W-1:0]  type_i,
   input  logic [SRC_W-1:0]  raw_i,
   input  logic [SRC_W-1:0]  en_i,
   output logic [SRC_W-1:0]  rdata_o
);
   logic [SRC_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr_i == ADDR_W'(OFF_STAT0))      sel = stat0_i;
      else if (addr_i == ADDR_W'(OFF_STAT1)) sel = stat1_i;
      else if (addr_i == ADDR_W'(OFF_TYPE))  sel = type_i;
      else if (addr_i == ADDR_W'(OFF_RAW))   sel = raw_i;
      else if (addr_i == ADDR_W'(OFF_SET))   sel = en_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_o <= '0;
      else if (re_i) rdata_o <= sel;
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int unsigned SRC_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic              bus_re_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [SRC_W-1:0]  bus_wdata_i,
   output logic [SRC_W-1:0]  bus_rdata_o,
   input  logic [SRC_W-1:0]  irq_src_i,
   output logic              cpu_irq0_o,
   output logic              cpu_irq1_o
);
   if (SRC_W < 2 || SRC_W > 32) begin : g_bad_w
      $error("irqc_top: SRC_W must be within 2..32");
   end
   if (ADDR_W < 6) begin : g_bad_a
      $error("irqc_top: ADDR_W must be at least 6");
   end

   logic [SRC_W-1:0] en_q, type_q, stat0, stat1;

   irqc_regs #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (bus_we_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .en_q_o   (en_q),
      .type_q_o (type_q)
   );

   irqc_route #(.SRC_W(SRC_W)) u_route (
      .raw_i   (irq_src_i),
      .en_i    (en_q),
      .type_i  (type_q),
      .stat0_o (stat0),
      .stat1_o (stat1)
   );

   irqc_out #(.SRC_W(SRC_W), .OUT_REG(OUT_REG)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stat0_i (stat0),
      .stat1_i (stat1),
      .irq0_o  (cpu_irq0_o),
      .irq1_o  (cpu_irq1_o)
   );

   irqc_rdmux #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .re_i    (bus_re_i),
      .addr_i  (bus_addr_i),
      .stat0_i (stat0),
      .stat1_i (stat1),
      .type_i  (type_q),
      .raw_i   (irq_src_i),
      .en_i    (en_q),
      .rdata_o (bus_rdata_o)
   );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [SRC_W-1:0]  bus_wdata_i,
   input logic [SRC_W-1:0]  irq_src_i,
   input logic [SRC_W-1:0]  en_q,
   input logic [SRC_W-1:0]  type_q,
   input logic              cpu_irq0_o,
   input logic              cpu_irq1_o
);
   localparam int unsigned GB = SRC_W - 1;

   // R2
   set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(OFF_SET))
      |=> ((en_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

   // R3
   clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(OFF_CLR))
      |=> ((en_q & $past(bus_wdata_i)) == '0));

   // R10
   ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && (bus_addr_i == ADDR_W'(OFF_STAT0) || bus_addr_i == ADDR_W'(OFF_STAT1)
                    || bus_addr_i == ADDR_W'(OFF_RAW)))
      |=> ($stable(en_q) && $stable(type_q)));

   if (OUT_REG) begin : g_reg_chk
      // R4
      gate_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !en_q[GB] |=> (!cpu_irq0_o && !cpu_irq1_o));

      // R9
      irq0_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> (cpu_irq0_o == $past(en_q[GB] && |(irq_src_i & en_q & ~type_q))));

      // R9
      irq1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> (cpu_irq1_o == $past(en_q[GB] && |(irq_src_i & en_q & type_q))));
   end else begin : g_comb_chk
      // R4
      gate_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !en_q[GB] |-> (!cpu_irq0_o && !cpu_irq1_o));
   end
endmodule

bind irqc_top irqc_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_src_i   (irq_src_i),
   .en_q        (en_q),
   .type_q      (type_q),
   .cpu_irq0_o  (cpu_irq0_o),
   .cpu_irq1_o  (cpu_irq1_o)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0, re = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0, rdata, src = '0;
   logic        irq0, irq1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqc_top u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_src_i(src), .cpu_irq0_o(irq0), .cpu_irq1_o(irq1)
   );

   // bench mirror of software-visible state
   logic [31:0] m_en = '0, m_typ = '0;

   function automatic logic [31:0] exp_stat(input bit line);
      logic [31:0] s;
      s = src & m_en & (line ? m_typ : ~m_typ);
      return m_en[31] ? s : 32'h0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (a == 8'h34) m_en = m_en | d;
      else if (a == 8'h38) m_en = m_en & ~d;
      else if (a == 8'h20) m_typ = d;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq0", {31'b0, irq0}, 32'h0);
      chk("R1 irq1", {31'b0, irq1}, 32'h0);
      rd(8'h34, v); chk("R1 enable", v, 32'h0);
      rd(8'h20, v); chk("R1 type", v, 32'h0);
   endtask

   task automatic t_set();
      logic [31:0] v;
      wr(8'h34, 32'h0000_00F0);
      wr(8'h34, 32'h0000_0003);
      rd(8'h34, v); chk("R2 set accumulates", v, 32'h0000_00F3);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(8'h38, 32'h0000_0030);
      rd(8'h34, v); chk("R3 clear selected", v, 32'h0000_00C3);
      rd(8'h38, v); chk("R3 clear reads zero", v, 32'h0);
      wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h34, v); chk("R3 clear all", v, 32'h0);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      src = 32'h0000_0001;
      wr(8'h34, 32'h0000_0001);
      settle();
      chk("R4 gate closed irq0", {31'b0, irq0}, 32'h0);
      rd(8'h00, v); chk("R4 gate closed status0", v, 32'h0);
      wr(8'h34, 32'h8000_0000);
      settle();
      chk("R4 gate open irq0", {31'b0, irq0}, 32'h1);
      rd(8'h00, v); chk("R6 status0", v, exp_stat(1'b0));
   endtask

   task automatic t_steer();
      logic [31:0] v;
      wr(8'h20, 32'h0000_0001);
      rd(8'h20, v); chk("R5 type readback", v, 32'h1);
      chk("R5 irq0 after steer", {31'b0, irq0}, 32'h0);
      chk("R5 irq1 after steer", {31'b0, irq1}, 32'h1);
      rd(8'h04, v); chk("R6 status1", v, exp_stat(1'b1));
      rd(8'h00, v); chk("R6 status0 empty", v, exp_stat(1'b0));
      wr(8'h20, 32'h0);
      settle();
      chk("R5 back to irq0", {31'b0, irq0}, 32'h1);
      chk("R5 irq1 low", {31'b0, irq1}, 32'h0);
   endtask

   task automatic t_raw();
      logic [31:0] v;
      src = 32'hA5A5_0000;
      rd(8'h30, v); chk("R7 raw unmasked", v, 32'hA5A5_0000);
      rd(8'h00, v); chk("R6 status0 mixed", v, exp_stat(1'b0));
      wr(8'h20, 32'h8000_0000);
      rd(8'h04, v); chk("R6 status1 mixed", v, exp_stat(1'b1));
      wr(8'h20, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      src = 32'h0000_0004;
      wr(8'h34, 32'h0000_0004);
      settle();
      chk("R8 pending", {31'b0, irq0}, 32'h1);
      wr(8'h38, 32'h0000_0004);
      settle();
      chk("R8 masked", {31'b0, irq0}, 32'h0);
      rd(8'h30, v); chk("R8 raw kept", v, 32'h4);
      wr(8'h34, 32'h0000_0004);
      settle();
      chk("R8 unmask restores", {31'b0, irq0}, 32'h1);
      src = 32'h0;
      settle();
      chk("R8 input drop", {31'b0, irq0}, 32'h0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      src = 32'h0000_0004;
      #1;
      chk("R9 not before edge", {31'b0, irq0}, 32'h0);
      @(negedge clk);
      chk("R9 after one edge", {31'b0, irq0}, 32'h1);
      src = 32'h0;
      @(negedge clk);
      chk("R9 falls after one edge", {31'b0, irq0}, 32'h0);
   endtask

   task automatic t_readonly();
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h34, v); chk("R10 enable untouched", v, m_en);
      rd(8'h20, v); chk("R10 type untouched", v, m_typ);
      rd(8'h10, v); chk("R10 unmapped 0x10", v, 32'h0);
      rd(8'h3C, v); chk("R10 unmapped 0x3C", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set();
      t_clear();
      t_gate();
      t_steer();
      t_raw();
      t_level();
      t_timing();
      t_readonly();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule